// File: doc/BRIEF.md
# Bus Role Mode Tracker

This block follows the role that a bus controller currently plays on a shared bus: idle (no connection), initiator, or target. It watches each command handed to the controller, sorts it into a command group from a field of its code, decides whether that command may be issued in the present role, and updates the role when a command or a bus event calls for it.

The role can change in two ways. A local command can change it: a select command makes the controller the initiator, and a reselect-sequence command makes it the target. A remote device can also change it: being selected by another device makes the controller the target, and being reselected by another device makes it the initiator. A bus-disconnect event returns the role to idle. When a command is not allowed in the current role, the block raises a one-cycle illegal-command pulse and leaves the role unchanged. All outputs are registered.

Top module: `mode_tracker`

## Requirements
- R1: `mode` is encoded as 00 = idle, 01 = initiator, 10 = target, and never takes the value 11. While `rst` is high and after it is released, `mode` is 00 and `illegal_irq` is 0.
- R2: `cmd_code[5:4]` selects the group: 00 = miscellaneous, 01 = initiator group, 10 = target group, 11 = setup group. Bits 7:6 are ignored. A miscellaneous command is legal in every role and leaves the role unchanged.
- R3: In the idle role, an initiator-group or target-group command raises `illegal_irq` in the cycle after `cmd_valid`, and the role stays idle.
- R4: In the idle role, a setup-group command whose `cmd_code[3:0]` is 0 to 3 (the select variants) is legal and makes the role initiator in the cycle after `cmd_valid`.
- R5: In the idle role, a setup-group command whose `cmd_code[3:0]` is 5 (reselect sequence) is legal and makes the role target in the cycle after `cmd_valid`.
- R6: In the idle role, a setup-group command whose `cmd_code[3:0]` is 4 (enable selection/reselection) or 6 to 15 is legal and leaves the role idle.
- R7: In the initiator role, initiator-group commands are legal and target-group commands are illegal. In the target role, target-group commands are legal and initiator-group commands are illegal. The role does not change in either case.
- R8: In the initiator or target role, every setup-group command is illegal and leaves the role unchanged.
- R9: A pulse on `remote_sel` makes the role target, and a pulse on `remote_resel` makes it initiator, from any role, in the next cycle.
- R10: A pulse on `bus_disc` makes the role idle in the next cycle, from any role.
- R11: When several things happen in one cycle, the new role follows this priority: `bus_disc`, then `remote_sel`, then `remote_resel`, then the command. The legality of a command is always judged against the role that held before that edge, and its pulse is raised even if an event overrides the role.
- R12: `illegal_irq` is high for exactly one cycle for each illegal command, and low in any cycle that follows a cycle without `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command code (group in bits 5:4, subcode in bits 3:0) |
| remote_sel | input | 1 | Another device selected this controller |
| remote_resel | input | 1 | Another device reselected this controller |
| bus_disc | input | 1 | Bus disconnect event |
| mode | output | 2 | Current role: 00 idle, 01 initiator, 10 target |
| illegal_irq | output | 1 | One-cycle illegal-command pulse |

## Verification
The assertions assume that each strobe and each event is a single-cycle pulse sampled on the clock edge, and that the three events may occur together in any mix, with the priority of R11 deciding the outcome. The bench keeps to this by driving every input on the falling edge and holding it for exactly one cycle. It reaches each role only through the block's own events, then sweeps all 256 command codes in each of the three roles, and every combination of the three events with a command. A following idle cycle confirms that each illegal pulse falls again.

// File: rtl/modetrk_pkg.sv
package modetrk_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_INIT = 2'b01,
    MODE_TARG = 2'b10
  } mode_t;

  typedef enum logic [1:0] {
    GRP_MISC  = 2'b00,
    GRP_INIT  = 2'b01,
    GRP_TARG  = 2'b10,
    GRP_SETUP = 2'b11
  } grp_t;

  typedef struct packed {
    grp_t grp;
    logic is_select;
    logic is_reselect;
  } cmd_class_t;

endpackage

// File: rtl/modetrk_decode.sv
module modetrk_decode
  import modetrk_pkg::*;
#(
  parameter int CMD_W        = 8,
  parameter int GRP_LSB      = 4,
  parameter int SUB_W        = 4,
  parameter int SEL_VARIANTS = 4,
  parameter int RESEL_SUB    = 5
) (
  input  logic [CMD_W-1:0] code,
  output cmd_class_t       cls
);
  localparam int GRP_MSB = GRP_LSB + 1;

  logic [1:0]       grp_bits;
  logic [SUB_W-1:0] sub;

  assign grp_bits = code[GRP_MSB:GRP_LSB];
  assign sub      = code[SUB_W-1:0];

  always_comb begin
    cls.grp         = grp_t'(grp_bits);
    cls.is_select   = (cls.grp == GRP_SETUP) && (int'(sub) < SEL_VARIANTS);
    cls.is_reselect = (cls.grp == GRP_SETUP) && (int'(sub) == RESEL_SUB);
  end

  initial begin
    assert (GRP_MSB < CMD_W) else $error("group field exceeds command width");
    assert (SUB_W <= GRP_LSB) else $error("subcode overlaps group field");
  end

endmodule

// File: rtl/modetrk_legal.sv
module modetrk_legal
  import modetrk_pkg::*;
(
  input  mode_t      cur_mode,
  input  cmd_class_t cls,
  output logic       legal
);
  always_comb begin
    unique case (cls.grp)
      GRP_MISC:  legal = 1'b1;
      GRP_INIT:  legal = (cur_mode == MODE_INIT);
      GRP_TARG:  legal = (cur_mode == MODE_TARG);
      GRP_SETUP: legal = (cur_mode == MODE_IDLE);
      default:   legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/modetrk_state.sv
module modetrk_state
  import modetrk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  cmd_class_t cls,
  input  logic       legal,
  input  logic       remote_sel,
  input  logic       remote_resel,
  input  logic       bus_disc,
  output mode_t      mode_q,
  output logic       illegal_q
);
  mode_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (bus_disc)
      mode_d = MODE_IDLE;
    else if (remote_sel)
      mode_d = MODE_TARG;
    else if (remote_resel)
      mode_d = MODE_INIT;
    else if (cmd_valid && legal) begin
      if (cls.is_select)
        mode_d = MODE_INIT;
      else if (cls.is_reselect)
        mode_d = MODE_TARG;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_IDLE;
      illegal_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      illegal_q <= cmd_valid && !legal;
    end
  end

  a_r1_mode_encoding: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'b11);

  a_r10_disc_to_idle: assert property (@(posedge clk) disable iff (rst)
    bus_disc |=> mode_q == MODE_IDLE);

  a_r9_remote_select: assert property (@(posedge clk) disable iff (rst)
    (!bus_disc && remote_sel) |=> mode_q == MODE_TARG);

  a_r9_remote_reselect: assert property (@(posedge clk) disable iff (rst)
    (!bus_disc && !remote_sel && remote_resel) |=> mode_q == MODE_INIT);

  a_r12_pulse_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !illegal_q);

  a_r3_idle_rejects_groups: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && mode_q == MODE_IDLE && (cls.grp == GRP_INIT || cls.grp == GRP_TARG))
      |=> illegal_q);

  a_r7_illegal_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !legal && !bus_disc && !remote_sel && !remote_resel)
      |=> $stable(mode_q));

  a_r2_misc_always_legal: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cls.grp == GRP_MISC) |=> !illegal_q);

endmodule

// File: rtl/mode_tracker.sv
module mode_tracker
  import modetrk_pkg::*;
#(
  parameter int CMD_W        = 8,
  parameter int GRP_LSB      = 4,
  parameter int SUB_W        = 4,
  parameter int SEL_VARIANTS = 4,
  parameter int RESEL_SUB    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             remote_sel,
  input  logic             remote_resel,
  input  logic             bus_disc,
  output logic [1:0]       mode,
  output logic             illegal_irq
);
  cmd_class_t cls;
  logic       legal;
  mode_t      mode_q;
  logic       illegal_q;

  modetrk_decode #(
    .CMD_W(CMD_W), .GRP_LSB(GRP_LSB), .SUB_W(SUB_W),
    .SEL_VARIANTS(SEL_VARIANTS), .RESEL_SUB(RESEL_SUB)
  ) u_decode (
    .code (cmd_code),
    .cls  (cls)
  );

  modetrk_legal u_legal (
    .cur_mode (mode_q),
    .cls      (cls),
    .legal    (legal)
  );

  modetrk_state u_state (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cls          (cls),
    .legal        (legal),
    .remote_sel   (remote_sel),
    .remote_resel (remote_resel),
    .bus_disc     (bus_disc),
    .mode_q       (mode_q),
    .illegal_q    (illegal_q)
  );

  assign mode        = mode_q;
  assign illegal_irq = illegal_q;

endmodule

// File: tb/tb_mode_tracker.sv
module tb_mode_tracker;
  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic       remote_sel;
  logic       remote_resel;
  logic       bus_disc;
  logic [1:0] mode;
  logic       illegal_irq;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  mode_tracker dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .remote_sel(remote_sel), .remote_resel(remote_resel), .bus_disc(bus_disc),
    .mode(mode), .illegal_irq(illegal_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected {illegal, next_mode} from the requirements.
  function automatic logic [2:0] model(input int m, input logic [7:0] c,
                                       input logic v, input logic d,
                                       input logic s, input logic r);
    logic [1:0] g = c[5:4];
    int sub = int'(c[3:0]);
    bit ok;
    int nm = m;
    case (g)
      2'b00:   ok = 1;
      2'b01:   ok = (m == 1);
      2'b10:   ok = (m == 2);
      default: ok = (m == 0);
    endcase
    if (d) nm = 0;
    else if (s) nm = 2;
    else if (r) nm = 1;
    else if (v && ok && g == 2'b11) begin
      if (sub < 4) nm = 1;
      else if (sub == 5) nm = 2;
    end
    return {v && !ok, 2'(nm)};
  endfunction

  function automatic string tag_for(input int m, input logic [7:0] c);
    logic [1:0] g = c[5:4];
    int sub = int'(c[3:0]);
    if (g == 2'b00) return "R2";
    if (m == 0 && g != 2'b11) return "R3";
    if (m == 0 && sub < 4) return "R4";
    if (m == 0 && sub == 5) return "R5";
    if (m == 0) return "R6";
    if (g == 2'b11) return "R8";
    return "R7";
  endfunction

  task automatic idle_inputs();
    cmd_valid = 0; cmd_code = '0; remote_sel = 0; remote_resel = 0; bus_disc = 0;
  endtask

  // Reach a role through the events, confirming R10 and R9 on the way.
  task automatic enter_mode(input int m);
    bus_disc = 1;
    @(negedge clk); idle_inputs();
    check(mode == 2'b00, "R10", mode, 0);
    if (m == 1) begin
      remote_resel = 1;
      @(negedge clk); idle_inputs();
      check(mode == 2'b01, "R9", mode, 1);
    end else if (m == 2) begin
      remote_sel = 1;
      @(negedge clk); idle_inputs();
      check(mode == 2'b10, "R9", mode, 2);
    end
  endtask

  task automatic run(input int m, input logic [7:0] c, input logic d,
                     input logic s, input logic r, input string tag);
    logic [2:0] e;
    enter_mode(m);
    e = model(m, c, 1'b1, d, s, r);
    cmd_valid = 1; cmd_code = c; bus_disc = d; remote_sel = s; remote_resel = r;
    @(negedge clk); idle_inputs();
    check(illegal_irq == e[2], tag, illegal_irq, e[2]);
    check(mode == e[1:0], tag, mode, e[1:0]);
    @(negedge clk);
    check(illegal_irq == 1'b0, "R12", illegal_irq, 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    @(negedge clk); @(negedge clk);
    check(mode == 2'b00, "R1", mode, 0);
    check(illegal_irq == 1'b0, "R1", illegal_irq, 0);
    rst = 0;
    @(negedge clk);
    check(mode == 2'b00, "R1", mode, 0);
    check(illegal_irq == 1'b0, "R1", illegal_irq, 0);

    // Every code in every role.
    for (int m = 0; m < 3; m++)
      for (int c = 0; c < 256; c++)
        run(m, 8'(c), 1'b0, 1'b0, 1'b0, tag_for(m, 8'(c)));

    // Event priority with a command in the same cycle.
    for (int m = 0; m < 3; m++)
      for (int ev = 1; ev < 8; ev++)
        foreach (cmd_code[i]) begin
          logic [7:0] c;
          c = (i % 2 == 0) ? 8'h31 : 8'h15;
          run(m, c, ev[2], ev[1], ev[0], "R11");
        end

    // Back-to-back illegal commands each give a pulse.
    enter_mode(0);
    cmd_valid = 1; cmd_code = 8'h10;
    @(negedge clk);
    check(illegal_irq == 1'b1, "R12", illegal_irq, 1);
    cmd_code = 8'h20;
    @(negedge clk); idle_inputs();
    check(illegal_irq == 1'b1, "R12", illegal_irq, 1);
    @(negedge clk);
    check(illegal_irq == 1'b0, "R12", illegal_irq, 0);
    check(mode == 2'b00, "R3", mode, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule